// File: doc/BRIEF.md
# Interrupt Recognition Core

This block is a cycle-stepped 8-bit accumulator sequencer that makes one bus access per cycle. Its purpose is to settle when a level-sensitive, active-low interrupt request is recognised. The request line passes through a register stage that is clocked every cycle. On the final cycle of each instruction, the sequencer combines the registered request with the interrupt mask held at that moment. If the request wins, the opcode read on the following fetch cycle is thrown away and the break opcode 0x00 goes to the decoder in its place. The break micro-sequence then performs the interrupt entry.

Because the decision is made at the end of an instruction, a change of the mask only takes effect one instruction later. For the same reason, an instruction whose own write pulls the interrupt line low is always followed by one more complete instruction. The core implements NOP (0xEA), SEI (0x78), CLI (0x58), load-immediate (0xA9), absolute store (0x8D) and BRK (0x00). Any other opcode behaves as a two-cycle NOP.

Top module: `irq_step_core`

## Requirements
- R1: After reset the first cycle is an opcode fetch (sync high, no write) at address 0x0000, with the interrupt mask set and the stack pointer at 0xFF.
- R2: The irq_n line is registered once per cycle before it is used. A level that first appears low during cycle d can only influence a decision made in cycle d+1 or later.
- R3: A request is taken when, in an instruction's final cycle, the registered request is active and the mask is clear. The next cycle then fetches at the unchanged PC, and 0x00 is decoded in place of the bus opcode.
- R4: After CLI with the line already low, exactly one further instruction completes before interrupt entry.
- R5: A request that is already registered during the final cycle of SEI is still taken right after SEI. The pushed status then has the mask bit (bit 2) set.
- R6: When an absolute store's write causes irq_n to go low from the next cycle, the next instruction is fetched and runs to completion before entry.
- R7: While the mask is set, a low irq_n never starts an entry.
- R8: Entry pushes PC high byte to 0x01SP, then PC low byte, then status (bit 5 = 1, bit 4 = break flag, bit 2 = mask), decrementing SP after each push. It then sets the mask, reads 0xFFFE and then 0xFFFF, and fetches next from the address formed by those two bytes. The 0xFFFE read comes 5 cycles after the substituted fetch.
- R9: For a hardware entry, the pushed return address equals the address of the discarded opcode, and the pushed break flag is 0.
- R10: A fetched 0x00 opcode (software break) pushes its own address plus 2, with the break flag set to 1.
- R11: Throughout the entry sequence and after it, while the mask stays set, a still-low irq_n causes no second entry.
- R12: Cycle counts: NOP, SEI, CLI and load-immediate take 2 cycles; absolute store takes 4 cycles, with the write in the 4th; BRK takes 7 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Level interrupt request, active low |
| bus_rdata | input | 8 | Read data, valid in the same cycle as bus_addr |
| bus_addr | output | 16 | Address of this cycle's access |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | High on a write cycle |
| sync | output | 1 | High on an opcode fetch cycle |

## Verification
On every cycle, the embedded properties check four things: a substitution only ever lands on a fetch cycle, it never follows a cycle in which the mask was set, the PC holds still across a substituted fetch, and the vector read happens with the mask already set. The remaining behaviour can only be shown by the bench's scenarios, which compare the exact cycle of the 0xFFFE read and the stacked bytes against arithmetic predictions. That covers the one-instruction mask delay after CLI and SEI, the extra instruction after a store that raises the line, the latch delay swept over every drop cycle, and the difference between software and hardware break frames.

// File: rtl/ics_pkg.sv
`timescale 1ns/1ps
package ics_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] OP_BRK = 8'h00;
    localparam logic [DATA_W-1:0] OP_NOP = 8'hEA;
    localparam logic [DATA_W-1:0] OP_SEI = 8'h78;
    localparam logic [DATA_W-1:0] OP_CLI = 8'h58;
    localparam logic [DATA_W-1:0] OP_STA = 8'h8D;
    localparam logic [DATA_W-1:0] OP_LDI = 8'hA9;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ir;
        logic [2:0]        t;
        logic              i_flag;
        logic              intr;
        logic [DATA_W-1:0] tmp_lo;
        logic [DATA_W-1:0] tmp_hi;
    } core_state_t;
endpackage

// File: rtl/ics_irq_latch.sv
`timescale 1ns/1ps
module ics_irq_latch #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    output logic pending
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = ~irq_n;
        end else begin : g_chain
            assign chain_d = {chain_q[STAGES-2:0], ~irq_n};
        end
    endgenerate

    // runs every cycle, whatever the sequencer is doing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pending = chain_q[STAGES-1];
endmodule

// File: rtl/ics_take_ctl.sv
`timescale 1ns/1ps
module ics_take_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic last_cyc,
    input  logic pending,
    input  logic mask,
    output logic inject
);
    logic take_d;
    logic take_q;

    always_comb begin
        take_d = last_cyc & pending & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) take_q <= 1'b0;
        else        take_q <= take_d;
    end

    assign inject = take_q;
endmodule

// File: rtl/ics_fetch_mux.sv
`timescale 1ns/1ps
module ics_fetch_mux #(
    parameter int          DW       = 8,
    parameter logic [7:0]  FORCE_OP = 8'h00
) (
    input  logic          inject,
    input  logic [DW-1:0] bus_op,
    output logic [DW-1:0] dec_op
);
    assign dec_op = inject ? DW'(FORCE_OP) : bus_op;
endmodule

// File: rtl/irq_step_core.sv
`timescale 1ns/1ps
module irq_step_core
    import ics_pkg::*;
#(
    parameter logic [15:0] RESET_PC    = 16'h0000,
    parameter logic [15:0] VEC_LO_ADDR = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE  = 8'h01,
    parameter int          LAT_STAGES  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_n,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_we,
    output logic        sync
);
    localparam logic [15:0] VEC_HI_ADDR = VEC_LO_ADDR + 16'd1;
    localparam core_state_t RESET_STATE = '{
        pc: RESET_PC, sp: 8'hFF, acc: 8'h00, ir: OP_NOP, t: 3'd0,
        i_flag: 1'b1, intr: 1'b0, tmp_lo: 8'h00, tmp_hi: 8'h00};

    core_state_t cs_q, cs_d;
    logic        pending;
    logic        inject;
    logic        last_cyc;
    logic [7:0]  dec_op;
    logic [7:0]  status_byte;

    ics_irq_latch #(.STAGES(LAT_STAGES)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .pending(pending));

    ics_take_ctl u_take (
        .clk(clk), .rst_n(rst_n), .last_cyc(last_cyc),
        .pending(pending), .mask(cs_q.i_flag), .inject(inject));

    ics_fetch_mux #(.DW(DATA_W), .FORCE_OP(OP_BRK)) u_mux (
        .inject(inject), .bus_op(bus_rdata), .dec_op(dec_op));

    assign status_byte = {2'b00, 1'b1, ~cs_q.intr, 1'b0, cs_q.i_flag, 2'b00};

    always_comb begin
        cs_d      = cs_q;
        bus_addr  = cs_q.pc;
        bus_wdata = 8'h00;
        bus_we    = 1'b0;
        sync      = 1'b0;
        last_cyc  = 1'b0;
        if (cs_q.t == 3'd0) begin
            // fetch: a substituted opcode leaves the PC on the discarded byte
            sync      = 1'b1;
            cs_d.ir   = dec_op;
            cs_d.intr = inject;
            cs_d.pc   = inject ? cs_q.pc : cs_q.pc + 16'd1;
            cs_d.t    = 3'd1;
        end else begin
            cs_d.t = cs_q.t + 3'd1;
            case (cs_q.ir)
                OP_STA: begin
                    case (cs_q.t)
                        3'd1: begin
                            cs_d.tmp_lo = bus_rdata;
                            cs_d.pc     = cs_q.pc + 16'd1;
                        end
                        3'd2: begin
                            cs_d.tmp_hi = bus_rdata;
                            cs_d.pc     = cs_q.pc + 16'd1;
                        end
                        default: begin
                            bus_addr  = {cs_q.tmp_hi, cs_q.tmp_lo};
                            bus_we    = 1'b1;
                            bus_wdata = cs_q.acc;
                            last_cyc  = 1'b1;
                            cs_d.t    = 3'd0;
                        end
                    endcase
                end
                OP_BRK: begin
                    case (cs_q.t)
                        3'd1: begin
                            if (!cs_q.intr) cs_d.pc = cs_q.pc + 16'd1;
                        end
                        3'd2: begin
                            bus_addr  = {STACK_PAGE, cs_q.sp};
                            bus_we    = 1'b1;
                            bus_wdata = cs_q.pc[15:8];
                            cs_d.sp   = cs_q.sp - 8'd1;
                        end
                        3'd3: begin
                            bus_addr  = {STACK_PAGE, cs_q.sp};
                            bus_we    = 1'b1;
                            bus_wdata = cs_q.pc[7:0];
                            cs_d.sp   = cs_q.sp - 8'd1;
                        end
                        3'd4: begin
                            bus_addr    = {STACK_PAGE, cs_q.sp};
                            bus_we      = 1'b1;
                            bus_wdata   = status_byte;
                            cs_d.sp     = cs_q.sp - 8'd1;
                            cs_d.i_flag = 1'b1;
                        end
                        3'd5: begin
                            bus_addr    = VEC_LO_ADDR;
                            cs_d.tmp_lo = bus_rdata;
                        end
                        default: begin
                            bus_addr = VEC_HI_ADDR;
                            cs_d.pc  = {bus_rdata, cs_q.tmp_lo};
                            last_cyc = 1'b1;
                            cs_d.t   = 3'd0;
                        end
                    endcase
                end
                OP_LDI: begin
                    cs_d.acc = bus_rdata;
                    cs_d.pc  = cs_q.pc + 16'd1;
                    last_cyc = 1'b1;
                    cs_d.t   = 3'd0;
                end
                OP_SEI: begin
                    cs_d.i_flag = 1'b1;
                    last_cyc    = 1'b1;
                    cs_d.t      = 3'd0;
                end
                OP_CLI: begin
                    cs_d.i_flag = 1'b0;
                    last_cyc    = 1'b1;
                    cs_d.t      = 3'd0;
                end
                default: begin
                    last_cyc = 1'b1;
                    cs_d.t   = 3'd0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= RESET_STATE;
        else        cs_q <= cs_d;
    end

    AST_INJECT_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        inject |-> sync); // R3
    AST_INJECT_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        inject |-> !$past(cs_q.i_flag)); // R7
    AST_RETURN_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && inject) |=> (cs_q.pc == $past(cs_q.pc))); // R9
    AST_VECTOR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !sync && bus_addr == VEC_LO_ADDR && cs_q.ir == OP_BRK) |-> cs_q.i_flag); // R11
endmodule

// File: tb/irq_step_core_test.sv
`timescale 1ns/1ps
module irq_step_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        we;
    logic        sync;
    logic [7:0]  mem [0:511];

    int n_run = 0;
    int n_fail = 0;
    int cyc, vec_cyc, vec_cnt, fetch_cnt, trig_cnt, drop_at, post_addr;
    logic running = 1'b0;
    logic [15:0] c0_addr;
    logic c0_sync, c0_we;

    always #2.5 clk = ~clk;

    irq_step_core uut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .bus_rdata(rdata),
        .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .sync(sync));

    always_comb begin
        if (addr == 16'hFFFE)      rdata = 8'h80;
        else if (addr == 16'hFFFF) rdata = 8'h00;
        else if (addr < 16'd512)   rdata = mem[addr[8:0]];
        else                       rdata = 8'hEA;
    end

    // mid-cycle monitor; the device at 0x0200 pulls irq_n low one cycle after its write
    initial begin
        forever begin
            @(negedge clk);
            if (running) begin
                if (cyc == drop_at) irq_n = 1'b0;
                if (cyc == 0) begin c0_addr = addr; c0_sync = sync; c0_we = we; end
                if (we && addr < 16'd512) mem[addr[8:0]] = wdata;
                if (we && addr == 16'h0200) begin trig_cnt++; drop_at = cyc + 1; end
                if (!we && addr == 16'hFFFE) begin
                    vec_cnt++;
                    if (vec_cyc < 0) vec_cyc = cyc;
                end
                if (sync && vec_cyc < 0) fetch_cnt++;
                if (sync && vec_cyc >= 0 && post_addr < 0) post_addr = int'(addr);
                cyc++;
            end
        end
    end

    initial begin
        #900000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'hEA;
    endtask

    task automatic run_prog(input int ncyc, input logic low_at_start, input int drop);
        running = 1'b0; rst_n = 1'b0;
        irq_n = low_at_start ? 1'b0 : 1'b1;
        cyc = 0; vec_cyc = -1; vec_cnt = 0; fetch_cnt = 0; trig_cnt = 0;
        drop_at = drop; post_addr = -1;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; running = 1'b1;
        repeat (ncyc) @(posedge clk);
        #1; running = 1'b0;
    endtask

    task automatic check_frame(input string req, input int vcyc, input int ret,
                               input int stat, input int nfetch);
        check({req, " vector cycle"}, vec_cyc, vcyc);
        check({req, " R9 return low"}, int'(mem[9'h1FE]), ret);
        check({req, " R8 return high"}, int'(mem[9'h1FF]), 0);
        check({req, " R8 status"}, int'(mem[9'h1FD]), stat);
        check({req, " fetches before entry"}, fetch_cnt, nfetch);
        check({req, " R11 single entry"}, vec_cnt, 1);
        check({req, " R8 handler address"}, post_addr, 16'h0080);
    endtask

    initial begin
        // line low from reset, k masked NOPs, CLI, then NOPs
        for (int k = 0; k < 6; k++) begin
            clear_mem();
            mem[k] = 8'h58;
            run_prog(2 * k + 40, 1'b1, -1);
            if (k == 0) begin
                check("R1 first address", int'(c0_addr), 0);
                check("R1 first sync", int'(c0_sync), 1);
                check("R1 first we", int'(c0_we), 0);
            end
            check_frame("R4", 2 * k + 9, k + 2, 8'h20, k + 3);
        end

        // CLI; NOP; STA $0200 raises the line; then instruction X (R6, R12)
        for (int x = 0; x < 5; x++) begin
            int len, ret, stat;
            clear_mem();
            mem[0] = 8'h58; mem[2] = 8'h8D; mem[3] = 8'h00; mem[4] = 8'h02;
            stat = 8'h20;
            case (x)
                0: begin mem[5] = 8'hEA; len = 2; ret = 6; end
                1: begin mem[5] = 8'h78; len = 2; ret = 6; stat = 8'h24; end // R5
                2: begin mem[5] = 8'h58; len = 2; ret = 6; end
                3: begin mem[5] = 8'hA9; mem[6] = 8'h5A; len = 2; ret = 7; end
                default: begin
                    mem[5] = 8'h8D; mem[6] = 8'h00; mem[7] = 8'h03; len = 4; ret = 8;
                end
            endcase
            run_prog(50, 1'b0, -1);
            check("R6 trigger write", trig_cnt, 1);
            check_frame(x == 1 ? "R5" : "R6", 13 + len, ret, stat, 5);
        end

        // masked at reset: STA $0200, m NOPs, CLI, NOP (R7)
        for (int m = 0; m < 5; m++) begin
            clear_mem();
            mem[0] = 8'h8D; mem[1] = 8'h00; mem[2] = 8'h02;
            mem[3 + m] = 8'h58;
            run_prog(50, 1'b0, -1);
            check_frame("R7", 2 * m + 13, m + 5, 8'h20, m + 4);
        end

        // software break after one NOP (R10)
        clear_mem();
        mem[1] = 8'h00;
        run_prog(30, 1'b0, -1);
        check("R10 vector cycle", vec_cyc, 7);
        check("R10 return low", int'(mem[9'h1FE]), 3);
        check("R10 status", int'(mem[9'h1FD]), 8'h34);
        check("R10 entries", vec_cnt, 1);

        // latch sweep: line drops mid-cycle d after CLI (R2, R3)
        for (int d = 2; d < 10; d++) begin
            int dec;
            clear_mem();
            mem[0] = 8'h58;
            run_prog(40, 1'b0, d);
            dec = (d % 2 == 0) ? d + 1 : d + 2;
            check("R2 vector cycle", vec_cyc, dec + 6);
            check("R3 return low", int'(mem[9'h1FE]), (dec + 1) / 2);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule